// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register front end placed between a host bus and a bank of interval-timer counter channels. The host writes control words to address 3 and data bytes to addresses 0 to 2, one address per channel. Reads are made from the same channel addresses. The front end stores each channel's access mode, counting mode and BCD flag. It assembles 16-bit reload values from byte writes and sends each value to the counter datapath as a one-cycle load strobe.

On the read side the block serves the live count supplied by each channel. Two kinds of snapshot take priority over the live count: a frozen copy of the count, and a status byte that holds the channel's output bit and its settings. Snapshots are requested with a per-channel count-latch control word, or with a read-back control word that can freeze counts, statuses or both on several channels in one write. Write and read use separate address inputs, so a read and a write can happen in the same cycle.

Top module: `tmr_host_if`

## Requirements
- R1: After synchronous reset every channel is in low-then-high access mode, counting mode 0 and binary (BCD off). Both byte toggles point at the low byte, no snapshot is held, `rdata` is 0x00 and no load strobe is active.
- R2: A control word written to address 3 uses bits 7:6 to select the channel (0 to 2). When its access field (bits 5:4) is non-zero, that field sets the access mode: 1 = low byte only, 2 = high byte only, 3 = low then high. In the same write, bits 3:1 set the counting mode and bit 0 sets the BCD flag. Mode codes 6 and 7 are stored as 2 and 3. The new settings appear on `ch_mode`/`ch_bcd` after the write's clock edge, and the outputs change on no other kind of cycle.
- R3: A data write to a channel loads a 16-bit value. In low-only mode the value is {0x00, byte}. In high-only mode it is {byte, 0x00}. In low-then-high mode the first byte is held and the second byte loads {second, first}. The load appears as a one-cycle `load_stb` bit for that channel, with the value on that channel's `load_val` slice, in the cycle after the completing write.
- R4: Without a snapshot, a read returns the live count according to the access mode: the low byte, the high byte, or, in low-then-high mode, low and high bytes in turn.
- R5: A control word that sets the access mode returns that channel's read toggle and write toggle to the low byte. A half-written value is then discarded.
- R6: A control word with access field 0 freezes the selected channel's live count. Later reads return the frozen count according to the access mode. In low-then-high mode the low byte is returned, then the high byte, and only then is the snapshot released.
- R7: A count or status freeze request for a channel that still holds an unread snapshot of the same kind is ignored.
- R8: The status byte is {output bit in bit 7, 0 in bit 6, access mode in bits 5:4, counting mode in bits 3:1, BCD in bit 0}. A pending status byte is returned on the next read and released, before any frozen count.
- R9: A control word with bits 7:6 = 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low freezes the count and bit 4 low freezes the status of every selected channel in that one write. Channels that are not selected are left unchanged.
- R10: A read from address 3 returns 0x00 and changes no channel state.
- R11: When a read and a control write touch the same channel in one cycle, the read acts first. It returns and releases the old snapshot, after which the write's freeze request is honoured. A toggle reset from the control word overrides the read's toggle advance.
- R12: `rdata` is registered. It takes the read result on the clock edge where `rd_en` is high and holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_addr | input | 2 | Write address: 0 to 2 channel data, 3 control word |
| wdata | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe for this cycle |
| rd_addr | input | 2 | Read address: 0 to 2 channel data, 3 returns zero |
| rdata | output | 8 | Registered read data |
| live_cnt | input | 48 | Live count of each channel, channel n in bits 16n+15:16n |
| live_out | input | 3 | Output bit of each channel |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Assembled reload value per channel, same slicing as live_cnt |
| ch_mode | output | 9 | Counting mode per channel, channel n in bits 3n+2:3n |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
Because read and write addresses are separate, a data read that consumes a snapshot can share a cycle with a control write that asks for a new snapshot of the same channel. The bench provokes this by freezing a channel and then changing its live count. In one cycle it reads that channel and writes a new count-latch command for it. It expects the read to return the old frozen byte and the following read to return the newly frozen value. The same kind of collision between a live read and a control word on one channel is judged by checking that the next read starts again at the low byte.

// File: rtl/tmr_pkg.sv
// Shared types for the interval timer host front end.
// Assumes a byte-wide host bus and counts of two bytes.
package tmr_pkg;

    // Access field encoding; the value 0 doubles as "no snapshot held".
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    // Map counting-mode codes 6 and 7 onto 2 and 3.
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/tmr_ctl_decode.sv
// Control and data write decoder.
// Turns one host write into per-channel command strobes: configure,
// freeze count, freeze status, data byte. Purely combinational.
// Assumes NUM_CH <= 3 so the read-back select bits fit in wdata[3:1].
module tmr_ctl_decode #(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] cfg_we,
    output logic [NUM_CH-1:0] cnt_frz,
    output logic [NUM_CH-1:0] sts_frz,
    output logic [NUM_CH-1:0] data_we
);
    localparam logic [1:0] CTL_ADDR = 2'd3;
    localparam logic [1:0] RB_SEL   = 2'd3;

    logic is_ctl;
    logic is_rb;
    logic acc_zero;

    // Classify the write as control word and read-back.
    assign is_ctl   = wr_en && (wr_addr == CTL_ADDR);
    assign is_rb    = is_ctl && (wdata[7:6] == RB_SEL);
    assign acc_zero = (wdata[5:4] == 2'd0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic tgt;
        logic rb_sel;
        // Channel targeted by a plain control word or picked by read-back.
        assign tgt        = is_ctl && (wdata[7:6] == 2'(g));
        assign rb_sel     = is_rb && wdata[g+1];
        assign cfg_we[g]  = tgt && !acc_zero;
        assign cnt_frz[g] = (tgt && acc_zero) || (rb_sel && !wdata[5]);
        assign sts_frz[g] = rb_sel && !wdata[4];
        assign data_we[g] = wr_en && (wr_addr == 2'(g));
    end

endmodule

// File: rtl/tmr_chan_port.sv
// Per-channel register port.
// Holds access mode, counting mode and BCD, the read and write byte
// toggles, the count snapshot and the status snapshot. Produces the byte
// a read would return this cycle and a registered load strobe.
// Assumes at most one of cfg_we / data_we / cnt_frz per cycle (one write).
module tmr_chan_port
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_acc,
    input  logic [2:0]          cfg_mode,
    input  logic                cfg_bcd,
    input  logic                cnt_frz,
    input  logic                sts_frz,
    input  logic                data_we,
    input  logic                data_re,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [2*BYTE_W-1:0] live_cnt,
    input  logic                live_out,
    output logic [BYTE_W-1:0]   rd_byte,
    output logic                load_stb,
    output logic [2*BYTE_W-1:0] load_val,
    output logic [2:0]          mode,
    output logic                bcd
);
    localparam int CNT_W = 2 * BYTE_W;

    acc_e              acc_q;
    logic [2:0]        mode_q;
    logic              bcd_q;
    logic              rd_tog_q;
    logic              wr_tog_q;
    logic [BYTE_W-1:0] hold_q;
    acc_e              snap_q;
    logic [CNT_W-1:0]  snap_cnt_q;
    logic              sts_vld_q;
    logic [BYTE_W-1:0] sts_q;
    logic              stb_q;
    logic [CNT_W-1:0]  val_q;

    acc_e              snap_rd;
    logic              sts_vld_rd;
    logic              rd_tog_rd;

    // Select the byte a read returns: status, then snapshot, then live.
    always_comb begin
        if (sts_vld_q) begin
            rd_byte = sts_q;
        end else begin
            case (snap_q)
                ACC_LO, ACC_WORD: rd_byte = snap_cnt_q[BYTE_W-1:0];
                ACC_HI:           rd_byte = snap_cnt_q[CNT_W-1:BYTE_W];
                default: begin
                    case (acc_q)
                        ACC_HI:   rd_byte = live_cnt[CNT_W-1:BYTE_W];
                        ACC_WORD: rd_byte = rd_tog_q ? live_cnt[CNT_W-1:BYTE_W]
                                                     : live_cnt[BYTE_W-1:0];
                        default:  rd_byte = live_cnt[BYTE_W-1:0];
                    endcase
                end
            endcase
        end
    end

    // State as left by this cycle's read, before any freeze request.
    always_comb begin
        snap_rd    = snap_q;
        sts_vld_rd = sts_vld_q;
        rd_tog_rd  = rd_tog_q;
        if (data_re) begin
            if (sts_vld_q) begin
                sts_vld_rd = 1'b0;
            end else if (snap_q != ACC_NONE) begin
                snap_rd = (snap_q == ACC_WORD) ? ACC_HI : ACC_NONE;
            end else if (acc_q == ACC_WORD) begin
                rd_tog_rd = !rd_tog_q;
            end
        end
    end

    // Settings, toggles and snapshots; the read acts before the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_WORD;
            mode_q     <= 3'd0;
            bcd_q      <= 1'b0;
            rd_tog_q   <= 1'b0;
            wr_tog_q   <= 1'b0;
            hold_q     <= '0;
            snap_q     <= ACC_NONE;
            snap_cnt_q <= '0;
            sts_vld_q  <= 1'b0;
            sts_q      <= '0;
        end else begin
            snap_q    <= snap_rd;
            sts_vld_q <= sts_vld_rd;
            rd_tog_q  <= rd_tog_rd;
            if (cnt_frz && (snap_rd == ACC_NONE)) begin
                snap_cnt_q <= live_cnt;
                snap_q     <= acc_q;
            end
            if (sts_frz && !sts_vld_rd) begin
                sts_q     <= {live_out, 1'b0, acc_q, mode_q, bcd_q};
                sts_vld_q <= 1'b1;
            end
            if (cfg_we) begin
                acc_q    <= acc_e'(cfg_acc);
                mode_q   <= fold_mode(cfg_mode);
                bcd_q    <= cfg_bcd;
                rd_tog_q <= 1'b0;
                wr_tog_q <= 1'b0;
            end
            if (data_we && (acc_q == ACC_WORD)) begin
                wr_tog_q <= !wr_tog_q;
                if (!wr_tog_q) begin
                    hold_q <= wdata;
                end
            end
        end
    end

    // Assemble the reload value and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            val_q <= '0;
        end else begin
            stb_q <= 1'b0;
            if (data_we) begin
                case (acc_q)
                    ACC_HI: begin
                        stb_q <= 1'b1;
                        val_q <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (wr_tog_q) begin
                            stb_q <= 1'b1;
                            val_q <= {wdata, hold_q};
                        end
                    end
                    default: begin
                        stb_q <= 1'b1;
                        val_q <= {{BYTE_W{1'b0}}, wdata};
                    end
                endcase
            end
        end
    end

    assign load_stb = stb_q;
    assign load_val = val_q;
    assign mode     = mode_q;
    assign bcd      = bcd_q;

endmodule

// File: rtl/tmr_host_if.sv
// Interval timer host register front end, top level.
// Decodes host writes, keeps one register port per channel and
// registers the read data. Assumes NUM_CH <= 3 (address 3 is control).
module tmr_host_if #(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_addr,
    input  logic [BYTE_W-1:0]            wdata,
    input  logic                         rd_en,
    input  logic [1:0]                   rd_addr,
    output logic [BYTE_W-1:0]            rdata,
    input  logic [NUM_CH*2*BYTE_W-1:0]   live_cnt,
    input  logic [NUM_CH-1:0]            live_out,
    output logic [NUM_CH-1:0]            load_stb,
    output logic [NUM_CH*2*BYTE_W-1:0]   load_val,
    output logic [NUM_CH*3-1:0]          ch_mode,
    output logic [NUM_CH-1:0]            ch_bcd
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [NUM_CH-1:0] cfg_we;
    logic [NUM_CH-1:0] cnt_frz;
    logic [NUM_CH-1:0] sts_frz;
    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] data_re;
    logic [BYTE_W-1:0] ch_rd [NUM_CH];
    logic [BYTE_W-1:0] rd_mux;

    tmr_ctl_decode #(
        .NUM_CH (NUM_CH),
        .BYTE_W (BYTE_W)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wdata   (wdata),
        .cfg_we  (cfg_we),
        .cnt_frz (cnt_frz),
        .sts_frz (sts_frz),
        .data_we (data_we)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Read strobe for this channel's data address.
        assign data_re[g] = rd_en && (rd_addr == 2'(g));

        tmr_chan_port #(
            .BYTE_W (BYTE_W)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[g]),
            .cfg_acc  (wdata[5:4]),
            .cfg_mode (wdata[3:1]),
            .cfg_bcd  (wdata[0]),
            .cnt_frz  (cnt_frz[g]),
            .sts_frz  (sts_frz[g]),
            .data_we  (data_we[g]),
            .data_re  (data_re[g]),
            .wdata    (wdata),
            .live_cnt (live_cnt[g*CNT_W +: CNT_W]),
            .live_out (live_out[g]),
            .rd_byte  (ch_rd[g]),
            .load_stb (load_stb[g]),
            .load_val (load_val[g*CNT_W +: CNT_W]),
            .mode     (ch_mode[g*3 +: 3]),
            .bcd      (ch_bcd[g])
        );
    end

    // Pick the addressed channel's byte; address 3 yields zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == 2'(i)) begin
                rd_mux = ch_rd[i];
            end
        end
    end

    // Register the read result on a read cycle, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/tmr_host_if_chk.sv
// Property checker for the timer host front end, bound to the top.
module tmr_host_if_chk #(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [1:0]                 wr_addr,
    input logic                       rd_en,
    input logic [1:0]                 rd_addr,
    input logic [BYTE_W-1:0]          rdata,
    input logic [NUM_CH-1:0]          load_stb,
    input logic [NUM_CH*3-1:0]        ch_mode,
    input logic [NUM_CH-1:0]          ch_bcd
);
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb)); // R3

    AST_LOAD_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != '0) |-> ($past(wr_en) && ($past(wr_addr) != 2'd3))); // R3

    AST_CTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == 2'd3)) |=> (rdata == '0)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R12

    AST_CFG_ON_CTL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == 2'd3)) |=> ($stable(ch_mode) && $stable(ch_bcd))); // R2

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
        AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
            !(ch_mode[g*3+2] && ch_mode[g*3+1])); // R2
    end

endmodule

bind tmr_host_if tmr_host_if_chk #(
    .NUM_CH (NUM_CH),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rdata    (rdata),
    .load_stb (load_stb),
    .ch_mode  (ch_mode),
    .ch_bcd   (ch_bcd)
);

// File: tb/tb_tmr_host_if.sv
// Scoreboard bench: driver tasks queue expected read bytes and loads,
// monitor processes pop and compare them as the design produces them.
module tb_tmr_host_if;
    localparam int NUM_CH = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      wr_en = 1'b0;
    logic [1:0]                wr_addr = '0;
    logic [7:0]                wdata = '0;
    logic                      rd_en = 1'b0;
    logic [1:0]                rd_addr = '0;
    logic [7:0]                rdata;
    logic [NUM_CH*CNT_W-1:0]   live_cnt = '0;
    logic [NUM_CH-1:0]         live_out = '0;
    logic [NUM_CH-1:0]         load_stb;
    logic [NUM_CH*CNT_W-1:0]   load_val;
    logic [NUM_CH*3-1:0]       ch_mode;
    logic [NUM_CH-1:0]         ch_bcd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic rd_seen = 1'b0;

    logic [7:0]  exp_q[$];
    string       tag_q[$];
    int          ld_ch_q[$];
    logic [15:0] ld_val_q[$];
    string       ld_tag_q[$];

    always #10 clk = !clk;

    tmr_host_if #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wdata(wdata), .rd_en(rd_en), .rd_addr(rd_addr), .rdata(rdata),
        .live_cnt(live_cnt), .live_out(live_out), .load_stb(load_stb),
        .load_val(load_val), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle; a read queues its expected byte.
    task automatic cyc(input logic we, input logic [1:0] wa, input logic [7:0] wd,
                       input logic re, input logic [1:0] ra, input logic [7:0] exp,
                       input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wdata = wd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 2'd0, 8'h00, "");
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, a, e, tag);
    endtask

    task automatic exp_load(input int ch, input logic [15:0] v, input string tag);
        ld_ch_q.push_back(ch);
        ld_val_q.push_back(v);
        ld_tag_q.push_back(tag);
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        live_cnt[ch*CNT_W +: CNT_W] = v;
    endtask

    // Note which edges carried a read.
    always @(posedge clk) rd_seen <= rst_n && rd_en;

    // Monitor: compare read bytes and load strobes against the queues.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R12 unexpected read actual=%0h expected=none", rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {24'd0, rdata}, {24'd0, e});
            end
        end
        if (rst_n && (load_stb != '0)) begin
            if (ld_ch_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R3 unexpected load actual=%0h expected=none", load_stb);
            end else begin
                automatic int c = ld_ch_q.pop_front();
                automatic logic [15:0] v = ld_val_q.pop_front();
                automatic string t = ld_tag_q.pop_front();
                check({t, " strobe"}, {29'd0, load_stb}, 32'(1 << c));
                check({t, " value"}, {16'd0, load_val[c*CNT_W +: CNT_W]}, {16'd0, v});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        set_live(0, 16'h1234);
        set_live(1, 16'hABCD);
        set_live(2, 16'h5A0F);
        live_out = 3'b101;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", {24'd0, rdata}, 32'h0);
        check("R1 load_stb", {29'd0, load_stb}, 32'h0);
        check("R1 mode", {23'd0, ch_mode}, 32'h0);
        check("R1 bcd", {29'd0, ch_bcd}, 32'h0);

        // R1/R4: default low-then-high live read.
        rd(0, 8'h34, "R1 R4 live low");
        rd(0, 8'h12, "R4 live high");

        // R3: two-byte load in default mode.
        wr(0, 8'h78);
        exp_load(0, 16'h5678, "R3 word load");
        wr(0, 8'h56);

        // R2: channel 1 low-only, mode 3, BCD on.
        wr(3, 8'h57);
        @(negedge clk);
        check("R2 ch1 mode", {29'd0, ch_mode[5:3]}, 32'd3);
        check("R2 ch1 bcd", {31'd0, ch_bcd[1]}, 32'd1);
        check("R2 ch0 untouched", {29'd0, ch_mode[2:0]}, 32'd0);
        exp_load(1, 16'h009A, "R3 low-only load");
        wr(1, 8'h9A);
        rd(1, 8'hCD, "R4 low-only read");
        rd(1, 8'hCD, "R4 low-only repeat");

        // R2: channel 2 high-only, mode 7 folded to 3.
        wr(3, 8'hAE);
        @(negedge clk);
        check("R2 ch2 mode fold", {29'd0, ch_mode[8:6]}, 32'd3);
        exp_load(2, 16'h4400, "R3 high-only load");
        wr(2, 8'h44);
        rd(2, 8'h5A, "R4 high-only read");
        rd(2, 8'h5A, "R4 high-only repeat");

        // R5: control word restarts both toggles.
        rd(0, 8'h34, "R5 pre low");
        wr(0, 8'h11);
        wr(3, 8'h34);
        rd(0, 8'h34, "R5 read restarts low");
        rd(0, 8'h12, "R5 then high");
        wr(0, 8'h22);
        exp_load(0, 16'h3322, "R5 write restarts low");
        wr(0, 8'h33);

        // R6/R7: count freeze, duplicate ignored, released after two bytes.
        wr(3, 8'h00);
        set_live(0, 16'h4321);
        wr(3, 8'h00);
        rd(0, 8'h34, "R6 R7 frozen low");
        rd(0, 8'h12, "R6 R7 frozen high");
        rd(0, 8'h21, "R6 released live low");
        rd(0, 8'h43, "R6 released live high");

        // R8/R9: read-back of channels 1 and 2, count and status.
        wr(3, 8'hCC);
        rd(1, 8'h17, "R8 R9 ch1 status");
        rd(1, 8'hCD, "R9 ch1 frozen count");
        rd(1, 8'hCD, "R9 ch1 live after");
        rd(2, 8'hA6, "R8 R9 ch2 status");
        rd(2, 8'h5A, "R9 ch2 frozen count");
        rd(2, 8'h5A, "R9 ch2 live after");
        rd(0, 8'h21, "R9 ch0 unselected live");

        // R8: status before count, then status-only read-back.
        wr(3, 8'hC2);
        rd(0, 8'hB4, "R8 status first");
        rd(0, 8'h21, "R8 count low after status");
        rd(0, 8'h43, "R8 count high after status");
        rd(0, 8'h43, "R8 live resumes toggle");
        wr(3, 8'hE2);
        rd(0, 8'hB4, "R8 status only");
        rd(0, 8'h21, "R8 no count frozen");

        // R10/R12: address 3 reads zero without side effects; rdata holds.
        rd(3, 8'h00, "R10 control read zero");
        rd(0, 8'h43, "R10 toggle unchanged");
        repeat (2) @(negedge clk);
        check("R12 rdata hold", {24'd0, rdata}, 32'h43);

        // R11: read releases old snapshot while same-cycle write refreezes.
        wr(3, 8'h40);
        set_live(1, 16'h1111);
        cyc(1'b1, 2'd3, 8'h40, 1'b1, 2'd1, 8'hCD, "R11 old snapshot read");
        set_live(1, 16'h2222);
        rd(1, 8'h11, "R11 new snapshot captured");
        rd(1, 8'h22, "R11 live after");

        // R11: control word beats read toggle advance.
        cyc(1'b1, 2'd3, 8'h34, 1'b1, 2'd0, 8'h21, "R11 live low with cfg");
        rd(0, 8'h21, "R11 toggle reset wins");

        repeat (3) @(negedge clk);
        check("R12 read queue drained", exp_q.size(), 0);
        check("R3 load queue drained", ld_ch_q.size(), 0);
        finish_run();
    end

endmodule